// File: doc/BRIEF.md
# Path RDI Instability Detector

This block watches the remote-defect-indication code taken from the path overhead of each received frame. It raises an unstable-defect flag when that code keeps changing from frame to frame. A per-frame strobe marks each new code. Every frame whose code differs from the one before it adds one to a change counter. When that counter reaches a 4-bit programmable threshold, the flag is declared.

A second counter measures how many frames in a row have carried the same code. The frame that brought a new code counts as the first frame of its run. When a run reaches the threshold length, the change counter returns to zero and the flag is withdrawn. Each time the flag changes, in either direction, the block emits a single-cycle interrupt pulse. Overhead byte extraction, frame alignment and software access to the threshold are handled outside the block.

Top module: `rdi_unstable_det`

## Requirements
- R1: After reset, `unstable` and `unstable_irq` are both 0.
- R2: The first strobed frame after reset only records its code. It is never counted as a change, whatever its value.
- R3: A strobed frame whose code differs from the previous strobed code adds one to the change count. `unstable` becomes 1 on the strobe where the count reaches a nonzero `thresh`.
- R4: The change count saturates at `thresh` and does not wrap. Further changes keep `unstable` at 1 and generate no interrupt.
- R5: When a run of identical codes reaches `thresh` frames, `unstable` returns to 0 on that strobe. The frame that started the run counts toward the run.
- R6: A run that reaches `thresh` frames also clears the change count when no defect is declared. A later declaration needs `thresh` fresh changes.
- R7: A strobed frame seen while `thresh` is 0 forces `unstable` to 0, and nothing is ever declared while `thresh` is 0.
- R8: `unstable_irq` is high for exactly the one cycle after each strobe edge on which `unstable` changed, and low at all other times.
- R9: Without `frame_stb`, the code input is ignored: no count, flag or interrupt changes, and the stored previous code is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_stb | input | 1 | One-cycle pulse marking a new frame's code |
| rdi_code | input | CODE_W (3) | RDI code extracted from the current frame |
| thresh | input | THR_W (4) | Programmable change and run threshold |
| unstable | output | 1 | Unstable-defect flag |
| unstable_irq | output | 1 | One-cycle pulse on every change of `unstable` |

## Verification
The bound checker checks four rules on every cycle:
- the flag and the interrupt stay still when there is no strobe;
- the interrupt matches a change of the flag exactly;
- the interrupt follows only strobe edges;
- a zero threshold forces the flag low.

Only the bench's frame sequences can show the counting behaviour. This covers when a declaration happens, saturation of the change count, and clearing by a run of identical codes that includes the frame that changed. It also covers the first-frame rule, and confirms that code values presented between strobes are not stored.

// File: rtl/rdi_unstable_det.sv
module rdi_unstable_det #(
  parameter int CODE_W = 3,
  parameter int THR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic [CODE_W-1:0] rdi_code,
  input  logic [THR_W-1:0]  thresh,
  output logic              unstable,
  output logic              unstable_irq
);

  logic              have_q;
  logic [CODE_W-1:0] prev_q;
  logic [THR_W-1:0]  chg_q;
  logic [THR_W-1:0]  run_q;
  logic              uns_q;
  logic              irq_q;

  logic              diff;
  logic              same;
  logic              thr_off;
  logic [THR_W-1:0]  chg_inc;
  logic [THR_W-1:0]  run_inc;
  logic              hit_set;
  logic              hit_clear;
  logic              uns_nxt;

  assign diff      = have_q && (rdi_code != prev_q);
  assign same      = have_q && (rdi_code == prev_q);
  assign thr_off   = (thresh == '0);
  assign chg_inc   = (chg_q >= thresh) ? thresh : chg_q + THR_W'(1);
  assign run_inc   = (&run_q) ? run_q : run_q + THR_W'(1);
  assign hit_set   = diff && !thr_off && (chg_inc >= thresh);
  assign hit_clear = same && (run_inc >= thresh);

  always_comb begin
    uns_nxt = uns_q;
    if (thr_off)        uns_nxt = 1'b0;
    else if (hit_set)   uns_nxt = 1'b1;
    else if (hit_clear) uns_nxt = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= '0;
      chg_q  <= '0;
      run_q  <= '0;
      uns_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else if (frame_stb) begin
      have_q <= 1'b1;
      prev_q <= rdi_code;
      run_q  <= same ? run_inc : THR_W'(1);
      if (diff)           chg_q <= chg_inc;
      else if (hit_clear) chg_q <= '0;
      uns_q  <= uns_nxt;
      irq_q  <= (uns_nxt != uns_q);
    end else begin
      irq_q  <= 1'b0;
    end
  end

  assign unstable     = uns_q;
  assign unstable_irq = irq_q;

endmodule

// File: rtl/rdi_unstable_det_chk.sv
module rdi_unstable_det_chk #(
  parameter int THR_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_stb,
  input logic [THR_W-1:0] thresh,
  input logic             unstable,
  input logic             unstable_irq
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !frame_stb) |=> ($stable(unstable) && !unstable_irq)); // R9

  AST_IRQ_MATCHES_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |=> (unstable_irq == (unstable != $past(unstable)))); // R8

  AST_IRQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !frame_stb) |=> !unstable_irq); // R8

  AST_ZERO_THR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && frame_stb && thresh == '0) |=> !unstable); // R7

endmodule

bind rdi_unstable_det rdi_unstable_det_chk #(.THR_W(THR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_stb    (frame_stb),
  .thresh       (thresh),
  .unstable     (unstable),
  .unstable_irq (unstable_irq)
);

// File: tb/sim_rdi_unstable_det.sv
module sim_rdi_unstable_det;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic [2:0] rdi_code = '0;
  logic [3:0] thresh = '0;
  logic       unstable;
  logic       unstable_irq;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rdi_unstable_det u0 (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .rdi_code(rdi_code),
    .thresh(thresh), .unstable(unstable), .unstable_irq(unstable_irq)
  );

  typedef struct { logic uns; logic irq; string tag; } exp_t;
  exp_t q[$];

  bit         m_have = 0;
  logic [2:0] m_prev = '0;
  int         m_chg = 0;
  int         m_run = 0;
  logic       m_uns = 0;

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic frame(input logic [2:0] c, input logic [3:0] t, input string tag);
    logic nu;
    exp_t e;
    @(negedge clk);
    nu = m_uns;
    if (!m_have) begin
      m_have = 1; m_run = 1;
    end else if (c != m_prev) begin
      m_run = 1;
      m_chg = (m_chg >= t) ? t : m_chg + 1;
      if (t != 0 && m_chg >= t) nu = 1;
    end else begin
      m_run = (m_run == 15) ? 15 : m_run + 1;
      if (m_run >= t) begin m_chg = 0; nu = 0; end
    end
    if (t == 0) nu = 0;
    e.uns = nu; e.irq = (nu != m_uns); e.tag = tag;
    q.push_back(e);
    m_uns = nu; m_prev = c;
    frame_stb = 1'b1; rdi_code = c; thresh = t;
    @(negedge clk);
    frame_stb = 1'b0;
  endtask

  always @(posedge clk) begin
    if (rst_n && frame_stb) begin
      exp_t e;
      @(negedge clk);
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R8 result without expected item: actual=%b expected=none", unstable);
      end else begin
        e = q.pop_front();
        check(e.tag, unstable, e.uns, "unstable");
        check(e.tag, unstable_irq, e.irq, "unstable_irq");
      end
    end
  end

  task automatic idle_toggle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rdi_code = rdi_code + 3'd3;
      check("R9", unstable, m_uns, "unstable idle");
      check("R9", unstable_irq, 1'b0, "unstable_irq idle");
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", unstable, 1'b0, "reset unstable");
    check("R1", unstable_irq, 1'b0, "reset irq");
    rst_n = 1'b1;

    frame(3'd5, 4'd1, "R2");
    frame(3'd5, 4'd1, "R2");
    frame(3'd2, 4'd1, "R3_R8");
    frame(3'd2, 4'd1, "R5_R8");

    frame(3'd1, 4'd3, "R3");
    frame(3'd2, 4'd3, "R3");
    frame(3'd1, 4'd3, "R3_R8");
    frame(3'd2, 4'd3, "R4");
    frame(3'd1, 4'd3, "R4");
    frame(3'd2, 4'd3, "R4");
    frame(3'd1, 4'd3, "R4");
    frame(3'd1, 4'd3, "R5");
    frame(3'd1, 4'd3, "R5_R8");

    frame(3'd2, 4'd3, "R6");
    frame(3'd2, 4'd3, "R6");
    frame(3'd2, 4'd3, "R6");
    frame(3'd1, 4'd3, "R6");
    frame(3'd2, 4'd3, "R6");
    frame(3'd1, 4'd3, "R6_R3");

    idle_toggle(5);
    frame(3'd1, 4'd3, "R9");
    frame(3'd1, 4'd3, "R5");

    frame(3'd4, 4'd0, "R7");
    frame(3'd6, 4'd0, "R7");
    frame(3'd4, 4'd0, "R7");
    frame(3'd6, 4'd0, "R7");
    frame(3'd4, 4'd2, "R3");
    frame(3'd6, 4'd2, "R3");
    frame(3'd0, 4'd0, "R7_R8");

    repeat (4) @(negedge clk);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL R8 pending expected items: actual=%0d expected=0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule